// File: doc/BRIEF.md
# CAN Transceiver Mode Controller

This block chooses the operating mode of a high-speed CAN transceiver. The four modes are Unpowered, Standby, Silent and Normal. The choice comes from three control pins and from some status flags. The pins are standby request, silent request (active low) and transmit data. The flags are two supply-undervoltage flags and one fail-safe error flag. The three pins arrive asynchronously, so each passes through a multi-stage synchronizer first. A two-bit state register then applies the transition rules. The supply and error flags come from blocks already in the controller's clock domain, so they act on the next edge.

The registered mode is decoded into the outputs:
- a transmitter enable;
- a high-speed receive comparator enable;
- a select that tells the receive path what to drive on the receive-data pin: a constant recessive level, the wake-up indication from the separate wake-up detector, or live comparator data;
- a driver-dominant strobe that is high only while transmitting a low bit.

A parameter builds a variant without the silent-request pin. In that variant the pin is ignored and treated as high.

Top module: `canmc_top`

## Requirements
- R1: While reset is asserted the mode code is 00 (Unpowered). The transmitter enable, comparator enable and driver-dominant outputs are 0, and the receive select is 0.
- R2: If either undervoltage flag is high at a rising edge, the mode after that edge is 00 (Unpowered). This holds from every mode and whatever the pins are.
- R3: Mode 00 is left only at an edge where both undervoltage flags are low. It always goes to 01 (Standby) first, and the standby pin has no effect while in 00.
- R4: From Silent (10) or Normal (11), a synchronized standby pin that is high moves the mode to 01.
- R5: From 01 or 10, with standby low, the next mode is 11 only when the silent-request pin is high, TXD is high and the error flag is low. Otherwise it is 10, so a low TXD never leads into Normal.
- R6: In 11 with standby low, the mode drops to 10 when the silent-request pin goes low or the error flag is set. A low TXD keeps the mode in 11.
- R7: With SYNC_STAGES=2, a pin change set up before a rising edge first affects the mode on the third rising edge.
- R8: The transmitter enable is 1 only in 11. The comparator enable is 1 in 10 and 11. The receive select is 0 in 00 (recessive), 1 in 01 (wake indication) and 2 in 10 and 11 (comparator data).
- R9: The driver-dominant output is 1 exactly when the mode is 11 and the synchronized TXD is low.
- R10: With HAS_NSIL=0, the silent-request pin has no effect and is treated as permanently high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_in | input | 1 | Standby request pin, asynchronous |
| nsil_in | input | 1 | Silent request pin (low = silent), asynchronous |
| txd_in | input | 1 | Transmit data pin, asynchronous |
| uv_vcc | input | 1 | Core supply undervoltage flag, synchronous |
| uv_vio | input | 1 | I/O supply undervoltage flag, synchronous |
| fail_err | input | 1 | Fail-safe error flag from the supervisor, synchronous |
| mode_o | output | 2 | Mode code: 00 Unpowered, 01 Standby, 10 Silent, 11 Normal |
| tx_en_o | output | 1 | Transmitter enable |
| rx_cmp_en_o | output | 1 | High-speed receive comparator enable |
| rxd_sel_o | output | 2 | Receive pin source: 0 recessive, 1 wake indication, 2 comparator |
| drv_dom_o | output | 1 | Driver dominant strobe |

## Verification
The bench builds two instances side by side on the same stimulus, both with SYNC_STAGES=2. One has HAS_NSIL=1 and the other HAS_NSIL=0. A low silent-request pin therefore splits their modes, which checks the pinless variant directly. The two-stage setting keeps the three-edge latency short enough to measure edge by edge. Random stimulus first settles the pin changes and then applies the flag changes, so every move among the four modes is exercised from a well-defined prior state.

// File: rtl/canmc_pkg.sv
package canmc_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_STBY   = 2'b01,
        MODE_LISTEN = 2'b10,
        MODE_ACTIVE = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        RXSRC_IDLE = 2'd0,
        RXSRC_WAKE = 2'd1,
        RXSRC_BUS  = 2'd2
    } rxsrc_e;

    typedef struct packed {
        mode_e mode;
    } fsm_st_t;

    typedef struct packed {
        logic   tx_en;
        logic   rx_en;
        rxsrc_e rx_src;
        logic   drv_dom;
    } out_t;

endpackage

// File: rtl/canmc_sync.sv
module canmc_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/canmc_fsm.sv
module canmc_fsm
    import canmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stby_s,
    input  logic  nsil_s,
    input  logic  txd_s,
    input  logic  uv,
    input  logic  err,
    output mode_e mode_o
);

    fsm_st_t st_d, st_q;
    logic    go_active;

    always_comb begin
        st_d      = st_q;
        go_active = nsil_s & txd_s & ~err;
        if (uv) begin
            st_d.mode = MODE_OFF;
        end else if (st_q.mode == MODE_OFF) begin
            st_d.mode = MODE_STBY;
        end else if (stby_s) begin
            st_d.mode = MODE_STBY;
        end else begin
            unique case (st_q.mode)
                MODE_ACTIVE: st_d.mode = (!nsil_s || err) ? MODE_LISTEN : MODE_ACTIVE;
                default:     st_d.mode = go_active ? MODE_ACTIVE : MODE_LISTEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_OFF};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

    AST_UV_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        uv |=> (st_q.mode == MODE_OFF)); // R2

    AST_OFF_EXITS_TO_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_OFF && !uv) |=> (st_q.mode == MODE_STBY)); // R3

    AST_STBY_PIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_s && !uv && st_q.mode != MODE_OFF) |=> (st_q.mode == MODE_STBY)); // R4

    AST_ACTIVE_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != MODE_ACTIVE) ##1 (st_q.mode == MODE_ACTIVE)
        |-> ($past(txd_s) && $past(nsil_s) && !$past(err))); // R5

    AST_ACTIVE_LEAVES_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_ACTIVE && !uv && !stby_s && (!nsil_s || err))
        |=> (st_q.mode == MODE_LISTEN)); // R6

endmodule

// File: rtl/canmc_decode.sv
module canmc_decode
    import canmc_pkg::*;
(
    input  mode_e mode,
    input  logic  txd_s,
    output out_t  out_o
);

    always_comb begin
        out_o = '{tx_en: 1'b0, rx_en: 1'b0, rx_src: RXSRC_IDLE, drv_dom: 1'b0};
        unique case (mode)
            MODE_OFF:    out_o.rx_src = RXSRC_IDLE;
            MODE_STBY:   out_o.rx_src = RXSRC_WAKE;
            MODE_LISTEN: begin
                out_o.rx_en  = 1'b1;
                out_o.rx_src = RXSRC_BUS;
            end
            MODE_ACTIVE: begin
                out_o.tx_en   = 1'b1;
                out_o.rx_en   = 1'b1;
                out_o.rx_src  = RXSRC_BUS;
                out_o.drv_dom = ~txd_s;
            end
        endcase
    end

endmodule

// File: rtl/canmc_top.sv
module canmc_top
    import canmc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit HAS_NSIL    = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stby_in,
    input  logic       nsil_in,
    input  logic       txd_in,
    input  logic       uv_vcc,
    input  logic       uv_vio,
    input  logic       fail_err,
    output logic [1:0] mode_o,
    output logic       tx_en_o,
    output logic       rx_cmp_en_o,
    output logic [1:0] rxd_sel_o,
    output logic       drv_dom_o
);

    localparam int NPINS = 3;

    logic [NPINS-1:0] pins_raw, pins_s;
    logic             nsil_eff;
    mode_e            mode;
    out_t             outs;

    assign pins_raw = {stby_in, nsil_in, txd_in};

    canmc_sync #(
        .W       (NPINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({NPINS{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_s)
    );

    always_comb begin
        nsil_eff = HAS_NSIL ? pins_s[1] : 1'b1;
    end

    canmc_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .stby_s (pins_s[2]),
        .nsil_s (nsil_eff),
        .txd_s  (pins_s[0]),
        .uv     (uv_vcc | uv_vio),
        .err    (fail_err),
        .mode_o (mode)
    );

    canmc_decode u_dec (
        .mode  (mode),
        .txd_s (pins_s[0]),
        .out_o (outs)
    );

    assign mode_o      = mode;
    assign tx_en_o     = outs.tx_en;
    assign rx_cmp_en_o = outs.rx_en;
    assign rxd_sel_o   = outs.rx_src;
    assign drv_dom_o   = outs.drv_dom;

    AST_TX_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_o |-> (mode_o == 2'b11)); // R8

    AST_DOM_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        drv_dom_o |-> (tx_en_o && rx_cmp_en_o)); // R9

    AST_OFF_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) |-> (rxd_sel_o == 2'd0 && !drv_dom_o)); // R8

endmodule

// File: tb/tb_canmc_top.sv
module tb_canmc_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stby = 1'b1, nsil = 1'b1, txd = 1'b1;
    logic uvc = 1'b0, uvv = 1'b0, err = 1'b0;

    logic [1:0] mode_a, sel_a, mode_b, sel_b;
    logic       tx_a, rx_a, dom_a, tx_b, rx_b, dom_b;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [1:0] exp_a, exp_b;

    always #4ns clk = ~clk;

    canmc_top #(.SYNC_STAGES(2), .HAS_NSIL(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .stby_in(stby), .nsil_in(nsil), .txd_in(txd),
        .uv_vcc(uvc), .uv_vio(uvv), .fail_err(err),
        .mode_o(mode_a), .tx_en_o(tx_a), .rx_cmp_en_o(rx_a),
        .rxd_sel_o(sel_a), .drv_dom_o(dom_a));

    canmc_top #(.SYNC_STAGES(2), .HAS_NSIL(1'b0)) dut_nonsil (
        .clk(clk), .rst_n(rst_n), .stby_in(stby), .nsil_in(nsil), .txd_in(txd),
        .uv_vcc(uvc), .uv_vio(uvv), .fail_err(err),
        .mode_o(mode_b), .tx_en_o(tx_b), .rx_cmp_en_o(rx_b),
        .rxd_sel_o(sel_b), .drv_dom_o(dom_b));

    function automatic logic [1:0] nxt(logic [1:0] m, logic sb, logic ns, logic tx,
                                       logic uvf, logic er);
        if (uvf)          return 2'b00;
        if (m == 2'b00)   return 2'b01;
        if (sb)           return 2'b01;
        if (m == 2'b11)   return (!ns || er) ? 2'b10 : 2'b11;
        return (ns && tx && !er) ? 2'b11 : 2'b10;
    endfunction

    function automatic logic [1:0] settle(logic [1:0] m, logic ns);
        logic [1:0] r = m;
        for (int i = 0; i < 4; i++) r = nxt(r, stby, ns, txd, uvc | uvv, err);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_outs(input string tag, input logic [1:0] m,
                            input logic [1:0] ma, input logic t, input logic r,
                            input logic [1:0] s, input logic d);
        chk({tag, " mode"}, {2'b0, ma}, {2'b0, m});
        chk("R8 tx_en", {3'b0, t}, {3'b0, (m == 2'b11)});
        chk("R8 rx_cmp_en", {3'b0, r}, {3'b0, m[1]});
        chk("R8 rxd_sel", {2'b0, s}, (m == 2'b00) ? 4'd0 : (m == 2'b01) ? 4'd1 : 4'd2);
        chk("R9 drv_dom", {3'b0, d}, {3'b0, (m == 2'b11) && !txd});
    endtask

    task automatic chk_both(input string tag);
        chk_outs(tag, exp_a, mode_a, tx_a, rx_a, sel_a, dom_a);
        chk_outs({tag, " R10"}, exp_b, mode_b, tx_b, rx_b, sel_b, dom_b);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step(input string tag, input logic sb, input logic ns, input logic tx,
                        input logic uc, input logic uo, input logic er);
        stby = sb; nsil = ns; txd = tx;
        cyc(3);
        exp_a = settle(exp_a, nsil);
        exp_b = settle(exp_b, 1'b1);
        chk_both(tag);
        uvc = uc; uvv = uo; err = er;
        cyc(3);
        exp_a = settle(exp_a, nsil);
        exp_b = settle(exp_b, 1'b1);
        chk_both(tag);
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(8ns * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: state held in reset
        cyc(2);
        exp_a = 2'b00; exp_b = 2'b00;
        chk_both("R1 reset");
        rst_n = 1'b1;
        cyc(1);
        exp_a = 2'b01; exp_b = 2'b01;
        chk_both("R3 leave off");

        // R7 latency and R5 no Normal with TXD low
        stby = 1'b0; txd = 1'b0;
        cyc(2);
        chk_both("R7 before third edge");
        cyc(1);
        exp_a = 2'b10; exp_b = 2'b10;
        chk_both("R5 txd low gives silent");

        step("R5 enter normal", 0, 1, 1, 0, 0, 0);
        step("R6 txd low stays normal", 0, 1, 0, 0, 0, 0);
        step("R6 nsil low R10", 0, 0, 0, 0, 0, 0);
        step("R5 back to normal", 0, 1, 1, 0, 0, 0);
        step("R6 error drops", 0, 1, 1, 0, 0, 1);
        step("R5 error blocks", 0, 1, 1, 0, 0, 1);
        step("R5 error clear", 0, 1, 1, 0, 0, 0);
        step("R4 standby pin", 1, 1, 1, 0, 0, 0);
        step("R5 from standby", 0, 1, 1, 0, 0, 0);

        // R2 undervoltage from Normal, R3 pins ignored while off
        uvv = 1'b1;
        cyc(1);
        exp_a = 2'b00; exp_b = 2'b00;
        chk_both("R2 uv forces off");
        stby = 1'b1; cyc(4);
        stby = 1'b0; cyc(4);
        chk_both("R3 stby ignored while off");
        uvv = 1'b0;
        cyc(1);
        exp_a = 2'b01; exp_b = 2'b01;
        chk_both("R3 recover to standby");
        cyc(3);
        exp_a = settle(exp_a, nsil);
        exp_b = settle(exp_b, 1'b1);
        chk_both("R5 after recovery");
        step("R2 vcc flag", 0, 1, 1, 1, 0, 0);
        step("R3 recover", 0, 1, 1, 0, 0, 0);

        for (int k = 0; k < 150; k++) begin
            step("R5 random",
                 ($urandom % 4) == 0, ($urandom % 3) != 0, ($urandom % 3) != 0,
                 ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 5) == 0);
        end
        report();
    end

endmodule